// File: doc/BRIEF.md
# Indirect VLAN Table Access Engine

This block holds a VLAN membership table of 4096 entries in an internal synchronous RAM. Software reaches it only through a small window of 16-bit registers. Each entry records three things: which ports are members of the VLAN, which of those ports send frames untagged, and a filtering ID.

To change an entry, the host first writes the VID and the entry fields into three staging words. It then writes a commit code into the command register. To inspect an entry, the host writes the VID into staging word 0, writes a fetch code into the command register, and collects the entry from three result words once the engine is idle again.

After reset, a sweep clears every entry while the engine reports busy. While the engine is busy it drops any further command. Command codes other than the two defined ones do nothing.

Top module: `vtab_engine`

## Requirements
- R1: From reset, `busy` stays high for exactly 4096 clock edges while every entry is cleared. After that, `busy` is low, and the result words at 0x018C, 0x018D and 0x018E read 0.
- R2: The staging words at 0x0185, 0x0186 and 0x0187 read back the full 16-bit value last written to them.
- R3: Writing 0x0F01 to the command register 0x0180 while idle does the following:
  - It stores the entry at the VID held in staging word 0, bits [11:0].
  - The member mask comes from word 1 bits [5:0], the untag mask from word 1 bits [13:8], and the FID from word 2 bits [2:0].
  - `busy` is high for exactly one cycle after the accepting edge.
- R4: Writing 0x0E01 to 0x0180 while idle fetches the entry at the VID in staging word 0.
  - `busy` is high for the two cycles after the accepting edge, and then the results are readable.
  - Result word 0 is the VID in bits [11:0].
  - Result word 1 is the member mask in bits [5:0] and the untag mask in bits [13:8].
  - Result word 2 is the FID in bits [2:0].
  - All other result bits read 0.
- R5: Mask bits beyond the six port bits, and FID bits above bit 2, are not stored; they read back as 0 after a fetch.
- R6: Any other value written to 0x0180 leaves `busy` low and the table unchanged.
- R7: A command written while `busy` is high is dropped. It neither extends `busy` nor alters the table.
- R8: A reset clears entries that were written before it.
- R9: Reading 0x0180 returns `busy` in bit 0 and 0 in all other bits.
- R10: Bits [15:12] of staging word 0 are ignored for addressing. VIDs 0 and 4095 are both usable.
- R11: The result words change only when a fetch completes. Staging writes and commits leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| busy | output | 1 | High during the init sweep or a table access |

## Verification
A corrupted entry, a stuck field bit or a wrong address becomes visible only through a fetch. In that case the wrong value appears in the result words two cycles after the fetch command. For this reason, every commit is followed by a fetch of the same VID, and a fetch of a different VID is included to catch aliasing. A sequencer that is in the wrong state shows up on `busy` in the very next cycle. It shows up as a wrong busy length, as busy being extended by a command that should have been dropped, or as results that change without a fetch.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam logic [15:0] ADDR_CMD   = 16'h0180;
  localparam logic [15:0] ADDR_STG0  = 16'h0185;
  localparam logic [15:0] ADDR_RES0  = 16'h018C;
  localparam logic [15:0] CODE_COMMIT = 16'h0F01;
  localparam logic [15:0] CODE_FETCH  = 16'h0E01;
  localparam int          WORDS       = 3;

  typedef enum logic [2:0] {
    ST_SWEEP   = 3'd0,
    ST_IDLE    = 3'd1,
    ST_COMMIT  = 3'd2,
    ST_FETCH   = 3'd3,
    ST_CAPTURE = 3'd4
  } seq_state_t;

  // place a narrow field into a 16-bit word at a bit offset
  function automatic logic [15:0] place(input logic [15:0] field, input int width, input int lsb);
    logic [15:0] msk;
    msk = (16'h1 << width) - 16'h1;
    return (field & msk) << lsb;
  endfunction

  // word offset of an address inside a bank of WORDS words, or -1
  function automatic int bank_slot(input logic [15:0] addr, input logic [15:0] base);
    if (addr >= base && addr < base + 16'(WORDS)) return int'(addr - base);
    return -1;
  endfunction
endpackage

// File: rtl/vtab_ram.sv
module vtab_ram #(
  parameter int AW = 12,
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end
endmodule

// File: rtl/vtab_regs.sv
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int VID_W = 12,
  parameter int PORTS = 6,
  parameter int FID_W = 3,
  localparam int ENTRY_W = 2 * PORTS + FID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [15:0]        reg_addr,
  input  logic [15:0]        reg_wdata,
  input  logic               busy,
  input  logic               res_load,
  input  logic [VID_W-1:0]   load_vid,
  input  logic [ENTRY_W-1:0] load_entry,
  output logic [15:0]        reg_rdata,
  output logic               cmd_wr,
  output logic [15:0]        cmd_val,
  output logic [VID_W-1:0]   stg_vid,
  output logic [ENTRY_W-1:0] stg_entry,
  output logic [VID_W-1:0]   res_vid_q,
  output logic [ENTRY_W-1:0] res_entry_q
);
  logic [15:0] stg_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_stage
    localparam logic [15:0] MY_ADDR = ADDR_STG0 + 16'(w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            stg_q[w] <= '0;
      else if (reg_we && reg_addr == MY_ADDR) stg_q[w] <= reg_wdata;
    end
  end

  assign cmd_wr  = reg_we && (reg_addr == ADDR_CMD);
  assign cmd_val = reg_wdata;

  // entry layout {fid, untag, member}; out-of-range bits are discarded here
  assign stg_vid   = stg_q[0][VID_W-1:0];
  assign stg_entry = {stg_q[2][FID_W-1:0], stg_q[1][8 +: PORTS], stg_q[1][PORTS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vid_q   <= '0;
      res_entry_q <= '0;
    end else if (res_load) begin
      res_vid_q   <= load_vid;
      res_entry_q <= load_entry;
    end
  end

  function automatic logic [15:0] result_word(input int slot, input logic [VID_W-1:0] vid,
                                              input logic [ENTRY_W-1:0] ent);
    logic [15:0] mem_f, unt_f, fid_f;
    mem_f = 16'(ent[PORTS-1:0]);
    unt_f = 16'(ent[PORTS +: PORTS]);
    fid_f = 16'(ent[2*PORTS +: FID_W]);
    case (slot)
      0:       return place(16'(vid), VID_W, 0);
      1:       return place(mem_f, PORTS, 0) | place(unt_f, PORTS, 8);
      default: return place(fid_f, FID_W, 0);
    endcase
  endfunction

  always_comb begin
    int s_slot, r_slot;
    s_slot = bank_slot(reg_addr, ADDR_STG0);
    r_slot = bank_slot(reg_addr, ADDR_RES0);
    reg_rdata = '0;
    if (reg_addr == ADDR_CMD)  reg_rdata = {15'd0, busy};
    else if (s_slot >= 0)      reg_rdata = stg_q[s_slot];
    else if (r_slot >= 0)      reg_rdata = result_word(r_slot, res_vid_q, res_entry_q);
  end
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
  import vtab_pkg::*;
#(
  parameter int VID_W   = 12,
  parameter int ENTRY_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [15:0]        cmd_val,
  input  logic [VID_W-1:0]   stg_vid,
  input  logic [ENTRY_W-1:0] stg_entry,
  output logic               busy,
  output logic               sweep_on,
  output logic               wr_accept,
  output logic               rd_accept,
  output logic               ram_we,
  output logic               ram_re,
  output logic [VID_W-1:0]   ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  output logic               res_load,
  output logic [VID_W-1:0]   op_vid
);
  seq_state_t          state_q, state_d;
  logic [VID_W-1:0]    sweep_q;
  logic [ENTRY_W-1:0]  op_entry;

  assign busy      = (state_q != ST_IDLE);
  assign sweep_on  = (state_q == ST_SWEEP);
  assign wr_accept = (state_q == ST_IDLE) && cmd_wr && (cmd_val == CODE_COMMIT);
  assign rd_accept = (state_q == ST_IDLE) && cmd_wr && (cmd_val == CODE_FETCH);
  assign res_load  = (state_q == ST_CAPTURE);

  always_comb begin
    state_d   = state_q;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = op_vid;
    ram_wdata = op_entry;
    case (state_q)
      ST_SWEEP: begin
        ram_we    = 1'b1;
        ram_addr  = sweep_q;
        ram_wdata = '0;
        if (&sweep_q) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (wr_accept)      state_d = ST_COMMIT;
        else if (rd_accept) state_d = ST_FETCH;
      end
      ST_COMMIT: begin
        ram_we  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FETCH: begin
        ram_re  = 1'b1;
        state_d = ST_CAPTURE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SWEEP;
      sweep_q  <= '0;
      op_vid   <= '0;
      op_entry <= '0;
    end else begin
      state_q <= state_d;
      if (sweep_on) sweep_q <= sweep_q + 1'b1;
      if (wr_accept || rd_accept) begin
        op_vid   <= stg_vid;
        op_entry <= stg_entry;
      end
    end
  end
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine #(
  parameter int VID_W = 12,
  parameter int PORTS = 6,
  parameter int FID_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [15:0] reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy
);
  localparam int ENTRY_W = 2 * PORTS + FID_W;

  logic               cmd_wr, sweep_on, wr_accept, rd_accept;
  logic               ram_we, ram_re, res_load;
  logic [15:0]        cmd_val;
  logic [VID_W-1:0]   stg_vid, ram_addr, op_vid, res_vid_q;
  logic [ENTRY_W-1:0] stg_entry, ram_wdata, ram_rdata, res_entry_q;

  vtab_regs #(.VID_W(VID_W), .PORTS(PORTS), .FID_W(FID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .res_load(res_load),
    .load_vid(op_vid), .load_entry(ram_rdata), .reg_rdata(reg_rdata),
    .cmd_wr(cmd_wr), .cmd_val(cmd_val), .stg_vid(stg_vid),
    .stg_entry(stg_entry), .res_vid_q(res_vid_q), .res_entry_q(res_entry_q)
  );

  vtab_seq #(.VID_W(VID_W), .ENTRY_W(ENTRY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .stg_vid(stg_vid), .stg_entry(stg_entry), .busy(busy),
    .sweep_on(sweep_on), .wr_accept(wr_accept), .rd_accept(rd_accept),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .res_load(res_load), .op_vid(op_vid)
  );

  vtab_ram #(.AW(VID_W), .DW(ENTRY_W)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/vtab_checker.sv
module vtab_checker
  import vtab_pkg::*;
#(
  parameter int VID_W   = 12,
  parameter int ENTRY_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               sweep_on,
  input logic               cmd_wr,
  input logic [15:0]        cmd_val,
  input logic               wr_accept,
  input logic               rd_accept,
  input logic               ram_we,
  input logic               res_load,
  input logic [VID_W-1:0]   res_vid_q,
  input logic [ENTRY_W-1:0] res_entry_q
);
  // R3: an accepted commit writes the RAM in the next cycle while busy
  a_r3_commit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (ram_we && busy));

  // R3: outside the sweep, a RAM write always follows an accepted commit
  a_r3_write_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !sweep_on) |-> $past(wr_accept));

  // R4: results are loaded two cycles after an accepted fetch
  a_r4_fetch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> ##1 res_load);

  // R7: no command is accepted while busy
  a_r7_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |-> !(wr_accept || rd_accept));

  // R6: an undefined code leaves the engine idle
  a_r6_ignore_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_val != CODE_COMMIT && cmd_val != CODE_FETCH) |=> !busy);

  // R11: result words hold unless a fetch completes
  a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> $stable({res_vid_q, res_entry_q}));
endmodule

bind vtab_engine vtab_checker #(.VID_W(VID_W), .ENTRY_W(ENTRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sweep_on(sweep_on),
  .cmd_wr(cmd_wr), .cmd_val(cmd_val), .wr_accept(wr_accept),
  .rd_accept(rd_accept), .ram_we(ram_we), .res_load(res_load),
  .res_vid_q(res_vid_q), .res_entry_q(res_entry_q)
);

// File: tb/sim_vtab_engine.sv
module sim_vtab_engine;
  localparam logic [15:0] CMD  = 16'h0180;
  localparam logic [15:0] STG0 = 16'h0185, STG1 = 16'h0186, STG2 = 16'h0187;
  localparam logic [15:0] RES0 = 16'h018C, RES1 = 16'h018D, RES2 = 16'h018E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_addr = '0, reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic busy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  vtab_engine u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy));

  typedef struct { bit is_busy; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.is_busy) check(it.tag, {15'd0, busy}, it.exp);
      else            check(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic expect_rd(logic [15:0] a, logic [15:0] e, string tag);
    item_t it;
    reg_addr = a;
    it.is_busy = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    tick();
  endtask

  task automatic expect_busy(logic e, string tag);
    item_t it;
    it.is_busy = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    sb.push_back(it);
    tick();
  endtask

  task automatic commit(logic [15:0] w0, logic [15:0] w1, logic [15:0] w2);
    wr(STG0, w0); wr(STG1, w1); wr(STG2, w2);
    wr(CMD, 16'h0F01);
    expect_busy(1'b1, "R3 busy one cycle");
    expect_busy(1'b0, "R3 idle after commit");
  endtask

  // fetch and compare all three result words; entry fields restated by requirement
  task automatic fetch_expect(logic [15:0] w0, logic [15:0] e1, logic [15:0] e2, string tag);
    wr(STG0, w0);
    wr(CMD, 16'h0E01);
    expect_busy(1'b1, "R4 busy cycle 1");
    expect_busy(1'b1, "R4 busy cycle 2");
    expect_rd(RES0, w0 & 16'h0FFF, tag);
    expect_rd(RES1, e1 & 16'h3F3F, tag);
    expect_rd(RES2, e2 & 16'h0007, tag);
  endtask

  task automatic wait_sweep;
    int n = 0;
    while (busy && n < 10000) begin tick(); n++; end
    check("R1 sweep length", 16'(n), 16'd4096);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_sweep();
    expect_rd(RES0, 16'h0, "R1 result0 zero");
    expect_rd(RES1, 16'h0, "R1 result1 zero");
    expect_rd(RES2, 16'h0, "R1 result2 zero");
    expect_rd(CMD,  16'h0, "R9 idle status");

    // R2 staging readback; R11 results untouched
    wr(STG0, 16'h0123); wr(STG1, 16'hABCD); wr(STG2, 16'h0005);
    expect_rd(STG0, 16'h0123, "R2 stage0");
    expect_rd(STG1, 16'hABCD, "R2 stage1");
    expect_rd(STG2, 16'h0005, "R2 stage2");
    expect_rd(RES1, 16'h0, "R11 staging leaves results");

    // R3 commit, R9 busy visible in status, R5 truncation
    wr(CMD, 16'h0F01);
    expect_rd(CMD, 16'h0001, "R9 busy status");
    expect_busy(1'b0, "R3 idle after commit");
    fetch_expect(16'h0123, 16'hABCD, 16'h0005, "R5 truncated entry");
    check("R5 member/untag encoding", 16'hABCD & 16'h3F3F, 16'h2B0D);

    // R10 upper VID bits ignored, VID extremes
    fetch_expect(16'hF123, 16'hABCD, 16'h0005, "R10 high bits ignored");
    commit(16'h0FFF, 16'h3F3F, 16'h0007);
    commit(16'h0000, 16'h0102, 16'h000A);
    fetch_expect(16'h0FFF, 16'h3F3F, 16'h0007, "R10 vid 4095");
    fetch_expect(16'h0000, 16'h0102, 16'h0002, "R10 vid 0");

    // R6 undefined codes
    wr(STG1, 16'h1111); wr(STG2, 16'h0003);
    wr(CMD, 16'h0F00);
    expect_busy(1'b0, "R6 code 0F00 ignored");
    wr(CMD, 16'h1E01);
    expect_busy(1'b0, "R6 code 1E01 ignored");
    fetch_expect(16'h0000, 16'h0102, 16'h0002, "R6 table unchanged");

    // R7 drop while busy after a commit
    wr(STG0, 16'h0200); wr(STG1, 16'h0102); wr(STG2, 16'h0003);
    wr(CMD, 16'h0F01);
    wr(CMD, 16'h0E01);
    expect_busy(1'b0, "R7 dropped fetch does not extend busy");
    // R7 drop a commit issued during a fetch
    wr(STG1, 16'h3F3F); wr(STG2, 16'h0006);
    wr(CMD, 16'h0E01);
    wr(CMD, 16'h0F01);
    expect_busy(1'b1, "R7 fetch still busy");
    expect_rd(RES1, 16'h0102, "R7 fetched entry");
    fetch_expect(16'h0200, 16'h0102, 16'h0003, "R7 table unchanged");

    // R11 commit does not alter results
    commit(16'h0200, 16'h0505, 16'h0001);
    expect_rd(RES1, 16'h0102, "R11 commit leaves results");
    expect_rd(RES0, 16'h0200, "R11 result vid held");
    fetch_expect(16'h0200, 16'h0505, 16'h0001, "R11 new entry after fetch");

    // R8 reset clears written entries
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    wait_sweep();
    fetch_expect(16'h0123, 16'h0000, 16'h0000, "R8 entry cleared");
    fetch_expect(16'h0FFF, 16'h0000, 16'h0000, "R8 vid 4095 cleared");

    tick(); tick();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule